// File: doc/BRIEF.md
# Filtered Low-Level Input Detector

This block watches one digitized input level and reports when that level has stayed low for a chosen filtering time. The raw level is first brought into the clock domain through a two-stage synchronizer. A delay counter then advances on timing ticks. The ticks come from one of two tick-enable inputs: a slow base rate, or a rate four times faster. The counter restarts whenever a high sample is seen.

Once the low level has lasted the whole selected delay, a status bit goes high. The rising edge of that status sets a sticky flag. The flag raises the interrupt request only while the interrupt enable is set. Software clears the flag by writing a 1 to it, which reaches the block as a one-cycle clear pulse. A detector enable switches the whole filter off.

Top module: `lowlvl_detect`

## Requirements
- R1: While `det_en` is 0, `delayed_low` is 0 one clock later, the delay count is discarded and `low_flag` is never set; the flag keeps its value.
- R2: With `dly_sel` = 2'b00 there is no filtering: `delayed_low` rises on the first clock edge after the synchronized level reads low.
- R3: The delay codes map to tick counts as follows: `dly_sel` = 2'b11 needs 4 ticks, 2'b10 needs 16 ticks and 2'b01 needs 64 ticks. These are the low-level ticks counted after synchronization, and `delayed_low` rises on the last of them.
- R4: With `fast_sel` = 0 the delay counts `tick_slow` pulses. With `fast_sel` = 1 it counts `tick_fast` pulses.
- R5: Any high synchronized sample clears `delayed_low` on the next edge and restarts the delay count from zero.
- R6: `low_flag` becomes 1 on the same edge on which `delayed_low` rises, and it stays 1 until it is cleared.
- R7: A one-cycle pulse on `flag_w1c` clears `low_flag` on the next edge. A new detection in that same cycle wins over the clear.
- R8: `irq` is 1 exactly when `low_flag` and `irq_en` are both 1.
- R9: The input passes through two flip-flops before it reaches the filter. With `dly_sel` = 2'b00, `delayed_low` rises on the third edge after `pin_level` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level | input | 1 | Digitized input level (asynchronous) |
| det_en | input | 1 | Detector enable |
| dly_sel | input | 2 | Delay code: 00 none, 01 longest, 10 longer, 11 shorter |
| fast_sel | input | 1 | Delay tick select: 0 slow, 1 fast |
| tick_slow | input | 1 | Slow base tick enable |
| tick_fast | input | 1 | Four-times-faster tick enable |
| irq_en | input | 1 | Interrupt enable |
| flag_w1c | input | 1 | Write-one-to-clear pulse for the flag |
| delayed_low | output | 1 | Filtered low-level state |
| low_flag | output | 1 | Sticky detection flag |
| irq | output | 1 | Interrupt request |

## Verification
A falling input reaches the filter after two edges. With no filtering, `delayed_low` and `low_flag` rise on edge 3. With N fast ticks, one per cycle, they rise on edge 2+N. The bench checks that the status is still 0 after edge 1+N and is 1 after edge 2+N.

Slow ticks come every fourth cycle, so the tick phase is not fixed. For that case the bench samples the status as still 0 after edge 4N-2 and as 1 after edge 4N+2. A clear pulse acts on the next edge, and `irq` follows the flag within the same cycle.

The bench drives every input on the falling clock edge. It counts edges with falling-edge waits, so each sample lands half a cycle after the edge that produced the value.

// File: rtl/lowlvl_detect.sv
module lowlvl_detect #(
  parameter int DLY_SHORT = 4,
  parameter int DLY_MID   = 16,
  parameter int DLY_LONG  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_level,
  input  logic       det_en,
  input  logic [1:0] dly_sel,
  input  logic       fast_sel,
  input  logic       tick_slow,
  input  logic       tick_fast,
  input  logic       irq_en,
  input  logic       flag_w1c,
  output logic       delayed_low,
  output logic       low_flag,
  output logic       irq
);
  localparam int CW = $clog2(DLY_LONG + 1);

  logic          sync_a, lvl_s;
  logic [CW-1:0] cnt;
  logic [CW-1:0] target;
  logic          tick, hit, dl_next, set_evt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_a <= 1'b1;
      lvl_s  <= 1'b1;
    end else begin
      sync_a <= pin_level;
      lvl_s  <= sync_a;
    end

  always_comb
    case (dly_sel)
      2'b01:   target = CW'(DLY_LONG);
      2'b10:   target = CW'(DLY_MID);
      2'b11:   target = CW'(DLY_SHORT);
      default: target = '0;
    endcase

  assign tick = fast_sel ? tick_fast : tick_slow;
  assign hit  = tick && (cnt >= target - 1'b1);

  always_comb
    if (!det_en || lvl_s)    dl_next = 1'b0;
    else if (dly_sel == 2'b00) dl_next = 1'b1;
    else                       dl_next = delayed_low || hit;

  assign set_evt = dl_next && !delayed_low;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                               cnt <= '0;
    else if (!det_en || lvl_s || delayed_low) cnt <= '0;
    else if (tick && !hit)                    cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      delayed_low <= 1'b0;
      low_flag    <= 1'b0;
    end else begin
      delayed_low <= dl_next;
      if (set_evt)       low_flag <= 1'b1;
      else if (flag_w1c) low_flag <= 1'b0;
    end

  assign irq = low_flag && irq_en;
endmodule

// File: rtl/lowlvl_detect_chk.sv
module lowlvl_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic det_en,
  input logic lvl_s,
  input logic flag_w1c,
  input logic irq_en,
  input logic delayed_low,
  input logic low_flag,
  input logic irq
);
  // R1
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |=> !delayed_low);
  // R5
  high_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_s |=> !delayed_low);
  // R6
  flag_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(delayed_low) |-> low_flag);
  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_flag && !flag_w1c |=> low_flag);
  // R7
  flag_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(low_flag) |-> $past(flag_w1c));
  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (low_flag && irq_en));
endmodule

bind lowlvl_detect lowlvl_detect_chk chk_i (
  .clk(clk), .rst_n(rst_n), .det_en(det_en), .lvl_s(lvl_s),
  .flag_w1c(flag_w1c), .irq_en(irq_en), .delayed_low(delayed_low),
  .low_flag(low_flag), .irq(irq)
);

// File: tb/lowlvl_detect_tb.sv
module lowlvl_detect_tb_top;
  logic clk = 0, rst_n = 0;
  logic pin_level = 1, det_en = 0, fast_sel = 0, irq_en = 0, flag_w1c = 0;
  logic [1:0] dly_sel = 2'b00;
  logic tick_slow = 0, tick_fast = 1;
  logic delayed_low, low_flag, irq;
  int checks = 0, errors = 0;
  logic [1:0] phase = 0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    phase <= phase + 1'b1;
    tick_slow <= (phase == 2'd3);
  end

  lowlvl_detect dut_i (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .det_en(det_en),
    .dly_sel(dly_sel), .fast_sel(fast_sel), .tick_slow(tick_slow),
    .tick_fast(tick_fast), .irq_en(irq_en), .flag_w1c(flag_w1c),
    .delayed_low(delayed_low), .low_flag(low_flag), .irq(irq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    pin_level = 1;
    edges(4);
    flag_w1c = 1;
    edges(1);
    flag_w1c = 0;
    edges(1);
  endtask

  task automatic t_reset();
    check("R6 reset flag", low_flag, 0);
    check("R5 reset status", delayed_low, 0);
    check("R8 reset irq", irq, 0);
  endtask

  task automatic t_nodelay();
    dly_sel = 2'b00;
    pin_level = 0;
    edges(2);
    check("R9 sync latency", delayed_low, 0);
    edges(1);
    check("R2 no delay", delayed_low, 1);
    check("R6 flag set", low_flag, 1);
    idle();
  endtask

  task automatic t_fast(input logic [1:0] code, input int n, input string req);
    dly_sel = code;
    fast_sel = 1;
    pin_level = 0;
    edges(1 + n);
    check(req, delayed_low, 0);
    edges(1);
    check(req, delayed_low, 1);
    check("R6 flag with status", low_flag, 1);
    idle();
  endtask

  task automatic t_irq();
    dly_sel = 2'b11;
    fast_sel = 1;
    irq_en = 0;
    pin_level = 0;
    edges(8);
    check("R8 irq masked", irq, 0);
    check("R6 flag held", low_flag, 1);
    irq_en = 1;
    #1 check("R8 irq enabled", irq, 1);
    edges(1);
    flag_w1c = 1;
    edges(1);
    flag_w1c = 0;
    check("R7 clear", low_flag, 0);
    check("R8 irq drops", irq, 0);
    check("R6 no re-set while low", delayed_low, 1);
    edges(3);
    check("R6 flag stays clear", low_flag, 0);
    irq_en = 0;
    idle();
  endtask

  task automatic t_slow();
    dly_sel = 2'b11;
    fast_sel = 0;
    pin_level = 0;
    edges(4 * 4 - 2);
    check("R4 slow not yet", delayed_low, 0);
    edges(4);
    check("R4 slow done", delayed_low, 1);
    idle();
  endtask

  task automatic t_glitch();
    dly_sel = 2'b10;
    fast_sel = 1;
    pin_level = 0;
    edges(12);
    check("R5 before glitch", delayed_low, 0);
    pin_level = 1;
    edges(1);
    pin_level = 0;
    edges(17);
    check("R5 restart", delayed_low, 0);
    edges(1);
    check("R5 full delay after restart", delayed_low, 1);
    pin_level = 1;
    edges(3);
    check("R5 status clears on high", delayed_low, 0);
    idle();
  endtask

  task automatic t_disable();
    dly_sel = 2'b00;
    det_en = 0;
    pin_level = 0;
    edges(10);
    check("R1 status off", delayed_low, 0);
    check("R1 flag not set", low_flag, 0);
    det_en = 1;
    edges(1);
    check("R1 active again", delayed_low, 1);
    det_en = 0;
    edges(1);
    check("R1 off drops status", delayed_low, 0);
    check("R1 flag kept", low_flag, 1);
    det_en = 1;
    idle();
  endtask

  task automatic t_set_wins();
    dly_sel = 2'b11;
    fast_sel = 1;
    pin_level = 0;
    edges(5);
    flag_w1c = 1;
    edges(1);
    flag_w1c = 0;
    check("R7 set wins over clear", low_flag, 1);
    idle();
  endtask

  initial begin
    edges(3);
    t_reset();
    rst_n = 1;
    det_en = 1;
    edges(4);
    t_nodelay();
    t_fast(2'b11, 4, "R3 code 11");
    t_fast(2'b10, 16, "R3 code 10");
    t_fast(2'b01, 64, "R3 code 01");
    t_irq();
    t_slow();
    t_glitch();
    t_disable();
    t_set_wins();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule